// File: doc/BRIEF.md
# Cascadable Linear-Array Readout Sequencer

This block is the digital scan controller of one segment of a linear image sensor built from several identical segments in a chain. A global start pulse goes to every segment at once. Each segment samples that pulse on the falling clock edge and begins a fixed pre-scan count of 29 clock slots. The segment marked as first in the chain then walks its 344 pixels, one per clock. It drives a one-hot select vector with a pixel-valid strobe.

A segment that is not first finishes its pre-scan and then waits for its local start input. That input is wired to the end-of-scan output of the segment before it. End-of-scan fires one pixel period before the last pixel of a segment. The next segment uses that one clock to arm its shift register. Its first pixel then appears in the clock right after its predecessor's last pixel, so a whole chain reads out as one unbroken stream.

Top module: `lsg_scan_seq`

## Requirements
- R1: A synchronous active-high reset forces pix_vld low, all pix_sel bits low and eos low. The segment stays in that idle state until a global start is seen.
- R2: gstart is sampled on the falling clock edge. Slot 1 is the state after the first rising edge that follows the capture. In slots 1 to 29, pix_vld is low and pix_sel is all zero.
- R3: With first_sel high, pixel 0 appears in slot 30. Pixels i = 0..343 follow in 344 consecutive slots. In each of them pix_vld is high and pix_sel has only bit i set.
- R4: With first_sel low, the segment keeps its outputs low after the pre-scan until lstart is seen high at a rising edge t. The cycle after t is an armed cycle with outputs still low. Pixel 0 appears in the cycle after that, and the remaining pixels follow one per clock.
- R5: eos is a pulse one clock wide. It is high exactly in the slot where pixel 342 is selected, which is one slot before the last pixel.
- R6: After pixel 343, pix_vld drops low and pix_sel is all zero until the next global start.
- R7: A global start that arrives during a scan aborts it. Output timing restarts from the new start as described in R2 to R4.
- R8: A segment with first_sel high ignores its lstart input.
- R9: Three chained segments give exactly 3×344 consecutive valid slots, from slot 30 to slot 1061. In each of those slots exactly one segment is valid, and no segment is valid outside them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; gstart is captured on its falling edge, all other logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| gstart | input | 1 | Global start pulse, shared by every segment |
| lstart | input | 1 | Local start, driven by the preceding segment's eos |
| first_sel | input | 1 | Static: high on the first segment, low on all others |
| pix_sel | output | NPIX | One-hot select of the current pixel, all zero when no pixel is selected |
| pix_vld | output | 1 | High while an active pixel is selected |
| eos | output | 1 | End-of-scan pulse, one slot before the last pixel |

## Verification
The assertions assume several things about the inputs. gstart is a pulse no more than one clock wide, because a held level is seen only once. first_sel stays constant between resets. lstart on a segment that is not first only rises as a predecessor's eos, so it arrives while the segment is waiting. The stimulus meets all three. It raises gstart just after a rising edge and clears it after the next rising edge. It ties first_sel per instance. It wires each later segment's lstart straight to the previous eos in a three-segment chain. It keeps the unused lstart of the first segment permanently high to show that input is ignored. Every slot of a full chain scan is compared with timing computed in the bench. An aborted scan and a mid-scan reset are checked the same way.

// File: rtl/lsg_pkg.sv
package lsg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_WAIT,
    ST_ARM,
    ST_SCAN
  } lsg_state_e;
endpackage

// File: rtl/lsg_gs_sampler.sv
module lsg_gs_sampler (
  input  logic clk,
  input  logic rst,
  input  logic gstart,
  output logic gs_hit
);
  logic gs_neg;
  logic gs_neg_d;

  always_ff @(negedge clk) begin
    if (rst) gs_neg <= 1'b0;
    else     gs_neg <= gstart;
  end

  always_ff @(posedge clk) begin
    if (rst) gs_neg_d <= 1'b0;
    else     gs_neg_d <= gs_neg;
  end

  assign gs_hit = gs_neg & ~gs_neg_d;

  // a held start produces one hit only (R7 restart is edge based)
  assert_hit_single_R7: assert property (@(posedge clk) disable iff (rst)
    gs_hit |=> !gs_hit);
endmodule

// File: rtl/lsg_prescan_cnt.sv
module lsg_prescan_cnt #(
  parameter int PRESCAN = 29
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic en,
  output logic term
);
  localparam int CW = $clog2(PRESCAN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (start)       cnt <= CW'(1);
    else if (en && !term) cnt <= cnt + CW'(1);
  end

  assign term = (cnt == CW'(PRESCAN));

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(PRESCAN));
  assert_cnt_start_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt == CW'(1)));
endmodule

// File: rtl/lsg_pixel_shifter.sv
module lsg_pixel_shifter #(
  parameter int NPIX = 344
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            load,
  input  logic            shift,
  output logic [NPIX-1:0] sel
);
  always_ff @(posedge clk) begin
    if (rst || clr) sel <= '0;
    else if (load)  sel <= {{(NPIX-1){1'b0}}, 1'b1};
    else if (shift) sel <= {sel[NPIX-2:0], 1'b0};
  end

  assert_sel_onehot0_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
  assert_load_first_R3: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> sel[0]);
endmodule

// File: rtl/lsg_scan_seq.sv
module lsg_scan_seq
  import lsg_pkg::*;
#(
  parameter int NPIX    = 344,
  parameter int PRESCAN = 29
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gstart,
  input  logic            lstart,
  input  logic            first_sel,
  output logic [NPIX-1:0] pix_sel,
  output logic            pix_vld,
  output logic            eos
);
  localparam int EOS_TAP  = NPIX - 3;
  localparam int LAST_TAP = NPIX - 1;

  lsg_state_e st;
  logic gs_hit;
  logic term;
  logic ld;
  logic sh;

  lsg_gs_sampler u_gs (
    .clk    (clk),
    .rst    (rst),
    .gstart (gstart),
    .gs_hit (gs_hit)
  );

  lsg_prescan_cnt #(.PRESCAN(PRESCAN)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .start (gs_hit),
    .en    (st == ST_INIT),
    .term  (term)
  );

  always_comb begin
    ld = !gs_hit && (((st == ST_INIT) && term && first_sel) || (st == ST_ARM));
    sh = !gs_hit && (st == ST_SCAN);
  end

  lsg_pixel_shifter #(.NPIX(NPIX)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .clr   (gs_hit),
    .load  (ld),
    .shift (sh),
    .sel   (pix_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      pix_vld <= 1'b0;
      eos     <= 1'b0;
    end else if (gs_hit) begin
      st      <= ST_INIT;
      pix_vld <= 1'b0;
      eos     <= 1'b0;
    end else begin
      eos <= (st == ST_SCAN) && pix_sel[EOS_TAP];
      case (st)
        ST_INIT: begin
          if (term) begin
            if (first_sel) begin
              st      <= ST_SCAN;
              pix_vld <= 1'b1;
            end else begin
              st <= ST_WAIT;
            end
          end
        end
        ST_WAIT: if (lstart) st <= ST_ARM;
        ST_ARM: begin
          st      <= ST_SCAN;
          pix_vld <= 1'b1;
        end
        ST_SCAN: begin
          if (pix_sel[LAST_TAP]) begin
            st      <= ST_IDLE;
            pix_vld <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!pix_vld && !eos && (pix_sel == '0)));
  assert_vld_sel_R3: assert property (@(posedge clk) disable iff (rst)
    pix_vld == ($countones(pix_sel) == 1));
  assert_vld_start_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pix_vld) |-> pix_sel[0]);
  assert_eos_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    eos |=> !eos);
  assert_eos_pos_R5: assert property (@(posedge clk) disable iff (rst)
    eos |-> (pix_vld && pix_sel[NPIX-2]));
  assert_after_last_R6: assert property (@(posedge clk) disable iff (rst)
    (pix_sel[LAST_TAP] && !gs_hit) |=> !pix_vld);
  assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
    gs_hit |=> (!pix_vld && (pix_sel == '0)));
  assert_arm_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (!first_sel && $rose(pix_vld)) |-> $past(lstart, 2));
endmodule

// File: tb/lsg_scan_seq_bench.sv
module lsg_scan_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPIX = 344;
  localparam int PRE  = 29;
  localparam int NSEG = 3;
  localparam int FIRST_SLOT = PRE + 1;
  localparam int LAST_SLOT  = FIRST_SLOT + NSEG * NPIX - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gstart = 1'b0;
  logic ls0 = 1'b1;
  logic [NPIX-1:0] sel_w [NSEG];
  logic [NSEG-1:0] vld_w;
  logic [NSEG-1:0] eos_w;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    if (g == 0) begin : g_first
      // R8: lstart of the first segment held high, must have no effect
      lsg_scan_seq #(.NPIX(NPIX), .PRESCAN(PRE)) u_lsg_scan_seq (
        .clk(clk), .rst(rst), .gstart(gstart), .lstart(ls0),
        .first_sel(1'b1), .pix_sel(sel_w[g]), .pix_vld(vld_w[g]),
        .eos(eos_w[g]));
    end else begin : g_next
      lsg_scan_seq #(.NPIX(NPIX), .PRESCAN(PRE)) u_lsg_scan_seq (
        .clk(clk), .rst(rst), .gstart(gstart), .lstart(eos_w[g-1]),
        .first_sel(1'b0), .pix_sel(sel_w[g]), .pix_vld(vld_w[g]),
        .eos(eos_w[g]));
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic string slot_tag(int s, int k);
    int st0 = FIRST_SLOT + s * NPIX;
    if (k < FIRST_SLOT) return "R2";
    if (k > st0 + NPIX - 1) return "R6";
    if (k == st0 + NPIX - 2) return "R5";
    if (s == 0) return "R3 R8";
    return "R4";
  endfunction

  // k = 0 means no scan is expected (idle after reset)
  task automatic check_slot(input int k, input bit idle);
    int nv = 0;
    for (int s = 0; s < NSEG; s++) begin
      int st0 = FIRST_SLOT + s * NPIX;
      bit ev = !idle && (k >= st0) && (k <= st0 + NPIX - 1);
      bit ee = !idle && (k == st0 + NPIX - 2);
      int ei = ev ? (k - st0) : -1;
      int ai = -1;
      int ones = $countones(sel_w[s]);
      string tg = idle ? "R1" : slot_tag(s, k);
      for (int b = 0; b < NPIX; b++) if (sel_w[s][b] && ai < 0) ai = b;
      if (vld_w[s]) nv++;
      chk(vld_w[s] == ev, tg, $sformatf("seg%0d slot%0d vld", s, k), int'(vld_w[s]), int'(ev));
      chk(eos_w[s] == ee, tg, $sformatf("seg%0d slot%0d eos", s, k), int'(eos_w[s]), int'(ee));
      chk((ones == (ev ? 1 : 0)) && (ai == ei), tg,
          $sformatf("seg%0d slot%0d sel index (ones=%0d)", s, k, ones), ai, ei);
    end
    if (!idle)
      chk(nv == (((k >= FIRST_SLOT) && (k <= LAST_SLOT)) ? 1 : 0), "R9",
          $sformatf("slot%0d valid segments", k), nv,
          ((k >= FIRST_SLOT) && (k <= LAST_SLOT)) ? 1 : 0);
  endtask

  task automatic start_and_check(input int nslots, inout int vcount);
    @(posedge clk); #1 gstart = 1'b1;
    @(posedge clk); #1 gstart = 1'b0;
    for (int k = 1; k <= nslots; k++) begin
      @(negedge clk);
      check_slot(k, 1'b0);
      vcount += $countones(vld_w);
    end
  endtask

  initial begin
    int vc;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: idle after reset, no start yet
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check_slot(0, 1'b1);
    end
    // R2..R6, R8, R9: full chain scan
    vc = 0;
    start_and_check(LAST_SLOT + 40, vc);
    chk(vc == NSEG * NPIX, "R9", "total valid slots", vc, NSEG * NPIX);
    // R7: abort mid-scan of the first segment, then full restart
    vc = 0;
    start_and_check(120, vc);
    vc = 0;
    start_and_check(LAST_SLOT + 10, vc);
    chk(vc == NSEG * NPIX, "R7", "valid slots after abort", vc, NSEG * NPIX);
    // R7: abort while the second segment is reading
    vc = 0;
    start_and_check(500, vc);
    vc = 0;
    start_and_check(LAST_SLOT + 5, vc);
    chk(vc == NSEG * NPIX, "R7", "valid slots after late abort", vc, NSEG * NPIX);
    // R1: reset mid-scan returns to idle
    vc = 0;
    start_and_check(200, vc);
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      check_slot(0, 1'b1);
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule